// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution unit of a load/store processor pipeline. Each operation is selected by a 4-bit opcode. The unit combines a first operand with a second operand that the shifter has already prepared. It produces a 32-bit result, a write strobe for the destination register and the next value of the four status flags: negative, zero, carry and overflow. The block is purely combinational and holds no state. The caller feeds back the current flags, and the carry flag in that vector serves as the carry-in for the chained add and subtract forms.

Sixteen operations are supported. There are six add and subtract forms, including reverse subtraction and carry-chained variants. There are four bitwise operations, including bit-clear, and two move forms that ignore the first operand. There are also four compare and test operations. These compute a value only to set the flags and never write the destination. The flags are updated when the set-flags input is high, and always for compare and test operations. Operands may be read as unsigned or as two's-complement values. The carry flag reports the unsigned outcome and the overflow flag reports the signed outcome.

Top module: `dp_alu`

## Requirements
- R1: The opcode `op_i` selects the operation. 0 ADD gives a+b. 1 ADC gives a+b+C. 2 SUB gives a-b. 3 SBC gives a-b+C-1. 4 RSB gives b-a. 5 RSC gives b-a+C-1. All results are taken modulo 2^32, and C is `flags_i[1]`.
- R2: Opcodes 6 AND, 7 OR, 8 XOR and 9 BIC (a AND NOT b) apply their operation independently to each of the 32 bit positions.
- R3: Opcode 10 MOV outputs b and opcode 11 MVN outputs NOT b. The value of a has no effect on either.
- R4: Opcodes 12 CMP (a-b), 13 CMN (a+b), 14 TST (a AND b) and 15 TEQ (a XOR b) place the computed value on `result_o` and drive `wr_en_o` low.
- R5: `wr_en_o` is high for every opcode from 0 to 11.
- R6: The flag vector is packed as {N,Z,C,V} in bits 3 down to 0. On an update, N equals bit 31 of the result, and Z is set exactly when the result is zero.
- R7: For the arithmetic opcodes (0 to 5, 12, 13), an update sets C to the unsigned carry out and V to the signed overflow. For a subtraction, C is 1 when no borrow occurs.
- R8: For the logic, move and test opcodes (6 to 11, 14, 15), an update sets C from `shift_carry_i` and copies V from `flags_i[0]`.
- R9: When `set_flags_i` is low and the opcode is not 12 to 15, `flags_o` equals `flags_i`.
- R10: Opcodes 12 to 15 update the flags whatever the level of `set_flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry out from the shifter |
| set_flags_i | input | 1 | Flag update enable |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the unit with the default width of 32. At that width the signed limits 0x7FFFFFFF and 0x80000000 and the unsigned wrap at 0xFFFFFFFF are reachable. The bench drives them directly so that carry and overflow can be told apart: for example 0x7FFFFFFF+1 overflows without a carry, and 0x80000000+0x80000000 does both. Random operands, random incoming flags and both carry-in values then exercise every opcode. These runs are compared against a reference model built on wider integer arithmetic.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_RSB = 4'd4,  OP_RSC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_XOR = 4'd8,  OP_BIC = 4'd9,  OP_MOV = 4'd10, OP_MVN = 4'd11,
    OP_CMP = 4'd12, OP_CMN = 4'd13, OP_TST = 4'd14, OP_TEQ = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op <= 4'd5) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic op_is_cmp(input logic [3:0] op);
    return op[3] & op[2];
  endfunction
endpackage

// File: rtl/dp_addsub.sv
module dp_addsub
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   full;

  // every form is x + y + cin with swapped / inverted operands
  always_comb begin
    x = a_i;
    y = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADC:          cin = c_i;
      OP_SUB, OP_CMP:  begin y = ~b_i; cin = 1'b1; end
      OP_SBC:          begin y = ~b_i; cin = c_i;  end
      OP_RSB:          begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC:          begin x = b_i; y = ~a_i; cin = c_i;  end
      default:         ;
    endcase
  end

  assign full   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (op_i)
        OP_AND, OP_TST: res_o[i] = a_i[i] & b_i[i];
        OP_OR:          res_o[i] = a_i[i] | b_i[i];
        OP_XOR, OP_TEQ: res_o[i] = a_i[i] ^ b_i[i];
        OP_BIC:         res_o[i] = a_i[i] & ~b_i[i];
        OP_MVN:         res_o[i] = ~b_i[i];
        default:        res_o[i] = b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_c_i,
  input  logic             arith_v_i,
  input  logic             shift_c_i,
  input  logic             set_i,
  input  alu_flags_t       cur_i,
  output alu_flags_t       nxt_o
);
  logic upd, arith;

  assign upd   = set_i | op_is_cmp(op_i);
  assign arith = op_is_arith(op_i);

  always_comb begin
    nxt_o = cur_i;
    if (upd) begin
      nxt_o.n = res_i[WIDTH-1];
      nxt_o.z = ~|res_i;
      nxt_o.c = arith ? arith_c_i : shift_c_i;
      nxt_o.v = arith ? arith_v_i : cur_i.v;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       flags_i,
  input  logic             shift_carry_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  alu_flags_t       cur, nxt;
  logic [WIDTH-1:0] sum, lres;
  logic             cout, ovf;

  assign cur = alu_flags_t'(flags_i);

  dp_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(cur.c),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  dp_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  assign result_o = op_is_arith(op_i) ? sum : lres;
  assign wr_en_o  = ~op_is_cmp(op_i);

  dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .op_i(op_i), .res_i(result_o), .arith_c_i(cout), .arith_v_i(ovf),
    .shift_c_i(shift_carry_i), .set_i(set_flags_i), .cur_i(cur), .nxt_o(nxt)
  );

  assign flags_o = nxt;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       flags_i,
  input logic             shift_carry_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_o
);
  logic upd, logic_op;
  assign upd      = set_flags_i | (op_i >= 4'd12);
  assign logic_op = (op_i >= 4'd6 && op_i <= 4'd11) || op_i >= 4'd14;

  always_comb begin
    if (!$isunknown(op_i)) begin
      AST_CMP_NO_WRITE: assert ((op_i >= 4'd12) == !wr_en_o); // R4
      AST_HOLD_FLAGS: assert (upd || flags_o == flags_i); // R9
      AST_ZERO_FLAG: assert (!upd || flags_o[2] == (result_o == '0)); // R6
      AST_NEG_FLAG: assert (!upd || flags_o[3] == result_o[WIDTH-1]); // R6
      AST_LOGIC_CARRY: assert (!(upd && logic_op) || flags_o[1] == shift_carry_i); // R8
      AST_LOGIC_V_KEEP: assert (!(upd && logic_op) || flags_o[0] == flags_i[0]); // R8
      AST_MOVE_PASS: assert (op_i != 4'd10 || result_o == b_i); // R3
    end
  end
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dp_alu_tb.sv
`timescale 1ns/1ps
module dp_alu_tb;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fin;
    logic        shc;
    logic        set;
    logic [31:0] res;
    logic [3:0]  fl;
    logic        we;
  } vec_t;

  // flags {N,Z,C,V}
  localparam vec_t VECS [17] = '{
    '{4'd0,  32'h7FFF_FFFF, 32'h1,         4'b0000, 1'b0, 1'b1, 32'h8000_0000, 4'b1001, 1'b1}, // R1 R7
    '{4'd2,  32'h0,         32'h1,         4'b0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1000, 1'b1}, // R1 R7
    '{4'd1,  32'hFFFF_FFFF, 32'h0,         4'b0010, 1'b0, 1'b1, 32'h0,         4'b0110, 1'b1}, // R1 R6
    '{4'd3,  32'h5,         32'h3,         4'b0000, 1'b0, 1'b1, 32'h1,         4'b0010, 1'b1}, // R1
    '{4'd4,  32'h1,         32'h0,         4'b0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1000, 1'b1}, // R1
    '{4'd5,  32'h2,         32'hA,         4'b0010, 1'b0, 1'b1, 32'h8,         4'b0010, 1'b1}, // R1
    '{4'd9,  32'hFF00_FF00, 32'h0F0F_0F0F, 4'b0001, 1'b1, 1'b1, 32'hF000_F000, 4'b1011, 1'b1}, // R2 R8
    '{4'd11, 32'h1234_5678, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1000, 1'b1}, // R3
    '{4'd12, 32'h5,         32'h5,         4'b0000, 1'b0, 1'b0, 32'h0,         4'b0110, 1'b0}, // R4 R10
    '{4'd15, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0001, 1'b0, 1'b0, 32'h0,         4'b0101, 1'b0}, // R4 R8
    '{4'd7,  32'h1,         32'h2,         4'b1010, 1'b0, 1'b0, 32'h3,         4'b1010, 1'b1}, // R2 R9
    '{4'd13, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b0, 32'h0,         4'b0111, 1'b0}, // R4 R7
    '{4'd8,  32'hF0,        32'hFF,        4'b0000, 1'b0, 1'b1, 32'h0F,        4'b0000, 1'b1}, // R2
    '{4'd6,  32'hFFFF_0000, 32'h00FF_FF00, 4'b0000, 1'b1, 1'b1, 32'h00FF_0000, 4'b0010, 1'b1}, // R2 R8
    '{4'd10, 32'hDEAD,      32'h8000_0000, 4'b0000, 1'b1, 1'b1, 32'h8000_0000, 4'b1010, 1'b1}, // R3 R5
    '{4'd14, 32'h0F,        32'hF0,        4'b0001, 1'b1, 1'b0, 32'h0,         4'b0111, 1'b0}, // R4 R10
    '{4'd2,  32'h8000_0000, 32'h1,         4'b0000, 1'b0, 1'b1, 32'h7FFF_FFFF, 4'b0011, 1'b1}  // R7
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0]   op;
  logic [W-1:0] a, b, res;
  logic [3:0]   fin, fout;
  logic         shc, set, we;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_alu #(.WIDTH(W)) u_dut (
    .op_i(op), .a_i(a), .b_i(b), .flags_i(fin), .shift_carry_i(shc),
    .set_flags_i(set), .result_o(res), .wr_en_o(we), .flags_o(fout)
  );

  function automatic void ref_model(input logic [3:0] o, input logic [31:0] x, y,
                                    input logic [3:0] f, input logic sc, st,
                                    output logic [31:0] r, output logic [3:0] fl,
                                    output logic w);
    longint unsigned ux = x, uy = y;
    longint sx = $signed(x), sy = $signed(y);
    longint c = f[1];
    longint sres;
    longint unsigned ures;
    bit arith = 1, cout, ovf;
    case (o)
      4'd0, 4'd13: begin ures = ux + uy;         sres = sx + sy;         cout = ures > 64'hFFFF_FFFF; end
      4'd1:  begin ures = ux + uy + c;           sres = sx + sy + c;     cout = ures > 64'hFFFF_FFFF; end
      4'd2, 4'd12: begin ures = ux - uy;         sres = sx - sy;         cout = ux >= uy; end
      4'd3:  begin ures = ux - uy + c - 1;       sres = sx - sy + c - 1; cout = (ux + c) >= (uy + 1); end
      4'd4:  begin ures = uy - ux;               sres = sy - sx;         cout = uy >= ux; end
      4'd5:  begin ures = uy - ux + c - 1;       sres = sy - sx + c - 1; cout = (uy + c) >= (ux + 1); end
      default: begin
        arith = 0; sres = 0; cout = 0;
        case (o)
          4'd6, 4'd14: ures = ux & uy;
          4'd7:        ures = ux | uy;
          4'd8, 4'd15: ures = ux ^ uy;
          4'd9:        ures = ux & (~uy & 64'hFFFF_FFFF);
          4'd10:       ures = uy;
          default:     ures = ~uy & 64'hFFFF_FFFF;
        endcase
      end
    endcase
    r = ures[31:0];
    ovf = arith && (sres > 64'sd2147483647 || sres < -64'sd2147483648);
    w = (o < 4'd12);
    fl = f;
    if (st || o >= 4'd12) fl = {r[31], r == 0, arith ? cout : sc, arith ? ovf : f[0]};
  endfunction

  task automatic apply_check(input logic [3:0] o, input logic [31:0] x, y,
                             input logic [3:0] f, input logic sc, st,
                             input logic [31:0] er, input logic [3:0] ef,
                             input logic ew, input string tag);
    @(negedge clk);
    op = o; a = x; b = y; fin = f; shc = sc; set = st;
    #1;
    n_vec++;
    if (res !== er || fout !== ef || we !== ew) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: res=%h flags=%b we=%b expected res=%h flags=%b we=%b",
               tag, o, x, y, res, fout, we, er, ef, ew);
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ew;
    op = 4'd0; a = '0; b = '0; fin = '0; shc = 0; set = 0;
    repeat (3) @(posedge clk);
    // reset state: idle inputs give ADD 0+0 with write, flags held (R5 R9)
    apply_check(4'd0, 0, 0, 4'b0000, 0, 0, 32'h0, 4'b0000, 1'b1, "R5 R9 reset");
    rst_ni = 1'b1;

    foreach (VECS[i])
      apply_check(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].fin, VECS[i].shc,
                  VECS[i].set, VECS[i].res, VECS[i].fl, VECS[i].we, "R1-table");

    // R3: move forms ignore a
    apply_check(4'd10, 32'hFFFF_FFFF, 32'h55, 4'b0000, 0, 0, 32'h55, 4'b0000, 1'b1, "R3 mov");
    apply_check(4'd11, 32'h0, 32'h55, 4'b0000, 0, 0, 32'hFFFF_FFAA, 4'b0000, 1'b1, "R3 mvn");
    // R9: flags held with set low on arithmetic overflow
    apply_check(4'd0, 32'h7FFF_FFFF, 32'h1, 4'b0100, 0, 0, 32'h8000_0000, 4'b0100, 1'b1, "R9 hold");
    // R7: carry-in both values on ADC and SBC
    apply_check(4'd1, 32'h7FFF_FFFF, 32'h0, 4'b0010, 0, 1, 32'h8000_0000, 4'b1001, 1'b1, "R7 adc c1");
    apply_check(4'd3, 32'h0, 32'h0, 4'b0000, 0, 1, 32'hFFFF_FFFF, 4'b1000, 1'b1, "R7 sbc c0");
    apply_check(4'd3, 32'h0, 32'h0, 4'b0010, 0, 1, 32'h0, 4'b0110, 1'b1, "R7 sbc c1");

    // random sweep over all opcodes (R1 R2 R4 R6 R7 R8 R10)
    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  o  = 4'(k % 16);
      logic [31:0] x  = $urandom;
      logic [31:0] y  = (k % 7 == 0) ? x : $urandom;
      logic [3:0]  f  = 4'($urandom);
      logic        sc = 1'($urandom);
      logic        st = 1'($urandom);
      ref_model(o, x, y, f, sc, st, er, ef, ew);
      apply_check(o, x, y, f, sc, st, er, ef, ew, "R1-R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule